// File: doc/BRIEF.md
# Angle and Velocity Parallel Output Stage

This block sits between a resolver tracking loop and a parallel data bus. Each time the loop strobes a fresh result, the block picks either the angle word or the velocity word and formats it for the chosen resolution. It then registers the word onto a 13-bit bus and marks the update with a pulse on an output data clock. A downstream reader latches the bus on the rising edge of that clock. A hold input freezes the bus so that a reader can take a consistent value. While the bus is held, or while the tracking loop is disabled by a fault, no clock pulse is produced.

The data clock comes from a three-state machine. `ST_IDLE` waits for an accepted sample. `ST_SETTLE` covers the one cycle in which freshly loaded data settles. `ST_HIGH` drives the clock high for `PULSE_CYC` cycles. The transitions are:
- idle-to-settle on an accepted sample.
- settle-to-high when no new sample arrives.
- settle-to-settle when another sample arrives.
- high-to-settle when a sample arrives mid-pulse.
- high-to-idle when the pulse count is reached.
- settle/high-to-idle (abort) when hold is asserted or the loop is disabled.

Top module: `ang_vel_bus_out`

## Requirements
- R1: When `smp_valid`, `hold_n` and `loop_en` are all high at a clock edge, `out_bus` shows the formatted word from that edge right after it, and every such update is followed by exactly one data-clock pulse.
- R2: While `hold_n` is low at an edge, `out_bus` does not change, and releasing hold does not load a sample that arrived while the bus was held.
- R3: While `loop_en` is low at an edge, `out_bus` does not change and no data-clock pulse starts.
- R4: With `sel_velocity`=0 and `res_12bit`=1, `out_bus` = {1'b0, angle_in[11:0]}. Angle is unsigned and bus bit 12 is 0.
- R5: With `sel_velocity`=0 and `res_12bit`=0, `out_bus` = {3'b000, angle_in[11:2]}, so bits 12..10 are 0.
- R6: With `sel_velocity`=1, velocity is two's complement. In 12-bit mode it is sign-extended from bit 11 to 13 bits. In 10-bit mode `velocity_in[11:2]` is sign-extended from its bit 9 to 13 bits.
- R7: `sel_velocity` and `res_12bit` are used only at the edge where the sample is accepted. Later changes do not alter the bus.
- R8: `out_clk` stays low in the cycle after an update, then stays high for exactly `PULSE_CYC` cycles. `out_bus` does not change while `out_clk` is high.
- R9: `out_clk` is low in any cycle where `hold_n` or `loop_en` is low. A pulse cut short this way does not resume when both inputs return high.
- R10: A sample accepted while `out_clk` is high drops `out_clk` at that edge, loads the new word, and starts a fresh pulse one cycle later.
- R11: While `rst_n` is low, `out_bus` is 0 and `out_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Tracking loop has a new result this cycle |
| angle_in | input | 12 | Unsigned angle word |
| velocity_in | input | 12 | Two's complement velocity word |
| sel_velocity | input | 1 | 0 selects angle, 1 selects velocity |
| res_12bit | input | 1 | 0 selects 10-bit, 1 selects 12-bit output |
| hold_n | input | 1 | High: follow new samples; low: hold the bus |
| loop_en | input | 1 | Tracking loop enabled (low in the fault state) |
| out_bus | output | 13 | Parallel data bus |
| out_clk | output | 1 | Data clock; its rising edge qualifies `out_bus` |

## Verification
Two functions can meet in one cycle.

The first case is a new sample arriving while the data clock of the previous sample is still high. The bench places a second strobe in the first high cycle. It then expects the clock to fall at the same edge that loads the new word, followed by a fresh pulse, and the scoreboard pairs each rising edge with its own word.

The second case is hold being asserted in the middle of a pulse. The bench checks that the clock drops in that same cycle and does not come back after hold is released.

// File: rtl/avb_pkg.sv
package avb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HIGH   = 2'd2
    } pulse_state_t;

endpackage

// File: rtl/avb_formatter.sv
module avb_formatter #(
    parameter int IN_W  = 12,
    parameter int LOW_W = 10,
    parameter int BUS_W = 13
) (
    input  logic [IN_W-1:0]  angle_in,
    input  logic [IN_W-1:0]  velocity_in,
    input  logic             sel_velocity,
    input  logic             res_12bit,
    output logic [BUS_W-1:0] word_out
);
    localparam int DROP   = IN_W - LOW_W;
    localparam int PAD_HI = BUS_W - IN_W;
    localparam int PAD_LO = BUS_W - LOW_W;

    logic [BUS_W-1:0] ang_full;
    logic [BUS_W-1:0] ang_low;
    logic [BUS_W-1:0] vel_full;
    logic [BUS_W-1:0] vel_low;

    // Angle: unsigned, zero-padded above the active resolution
    assign ang_full = {{PAD_HI{1'b0}}, angle_in};
    assign ang_low  = {{PAD_LO{1'b0}}, angle_in[IN_W-1:DROP]};

    // Velocity: signed, sign-extended to the full bus width
    assign vel_full = {{PAD_HI{velocity_in[IN_W-1]}}, velocity_in};
    assign vel_low  = {{PAD_LO{velocity_in[IN_W-1]}}, velocity_in[IN_W-1:DROP]};

    always_comb begin
        unique case ({sel_velocity, res_12bit})
            2'b00:   word_out = ang_low;
            2'b01:   word_out = ang_full;
            2'b10:   word_out = vel_low;
            default: word_out = vel_full;
        endcase
    end
endmodule

// File: rtl/avb_capture.sv
module avb_capture #(
    parameter int BUS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] word_in,
    output logic [BUS_W-1:0] bus_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else if (load) begin
            bus_q <= word_in;
        end
    end
endmodule

// File: rtl/avb_pulse_fsm.sv
module avb_pulse_fsm
    import avb_pkg::*;
#(
    parameter int PULSE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic run,
    output logic clk_out
);
    localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYC - 1);

    pulse_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // High-phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_HIGH) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!run)      state_d = ST_IDLE;
                else if (take) state_d = ST_SETTLE;
                else           state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!run)               state_d = ST_IDLE;
                else if (take)          state_d = ST_SETTLE;
                else if (cnt_q == LAST) state_d = ST_IDLE;
                else                    state_d = ST_HIGH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output: clock high only in the high phase and while running
    always_comb begin
        clk_out = (state_q == ST_HIGH) && run;
    end
endmodule

// File: rtl/ang_vel_bus_out.sv
module ang_vel_bus_out #(
    parameter int IN_W      = 12,
    parameter int LOW_W     = 10,
    parameter int BUS_W     = 13,
    parameter int PULSE_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [IN_W-1:0]  angle_in,
    input  logic [IN_W-1:0]  velocity_in,
    input  logic             sel_velocity,
    input  logic             res_12bit,
    input  logic             hold_n,
    input  logic             loop_en,
    output logic [BUS_W-1:0] out_bus,
    output logic             out_clk
);
    logic             run;
    logic             take;
    logic [BUS_W-1:0] fmt_word;

    assign run  = hold_n & loop_en;
    assign take = smp_valid & run;

    avb_formatter #(
        .IN_W (IN_W),
        .LOW_W(LOW_W),
        .BUS_W(BUS_W)
    ) u_fmt (
        .angle_in    (angle_in),
        .velocity_in (velocity_in),
        .sel_velocity(sel_velocity),
        .res_12bit   (res_12bit),
        .word_out    (fmt_word)
    );

    avb_capture #(
        .BUS_W(BUS_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take),
        .word_in(fmt_word),
        .bus_q  (out_bus)
    );

    avb_pulse_fsm #(
        .PULSE_CYC(PULSE_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .run    (run),
        .clk_out(out_clk)
    );
endmodule

// File: rtl/avb_checker.sv
module avb_checker #(
    parameter int IN_W  = 12,
    parameter int BUS_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             hold_n,
    input logic             loop_en,
    input logic [BUS_W-1:0] out_bus,
    input logic             out_clk
);
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |-> (out_bus == '0) && !out_clk);

    p_hold_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> $stable(out_bus));

    p_loop_off_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> $stable(out_bus));

    p_abort_clk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n || !loop_en) |=> !out_clk);

    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_clk |-> $stable(out_bus));
endmodule

bind ang_vel_bus_out avb_checker #(
    .IN_W (IN_W),
    .BUS_W(BUS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .hold_n   (hold_n),
    .loop_en  (loop_en),
    .out_bus  (out_bus),
    .out_clk  (out_clk)
);

// File: tb/sim_ang_vel_bus_out.sv
module sim_ang_vel_bus_out;
    localparam int CLK_PER = 10;
    localparam int PULSE   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] angle_in = '0;
    logic [11:0] velocity_in = '0;
    logic        sel_velocity = 1'b0;
    logic        res_12bit = 1'b1;
    logic        hold_n = 1'b1;
    logic        loop_en = 1'b1;
    logic [12:0] out_bus;
    logic        out_clk;

    int checks = 0;
    int errors = 0;
    logic [12:0] expq[$];
    logic        prev_clk = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    ang_vel_bus_out #(.PULSE_CYC(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .angle_in(angle_in), .velocity_in(velocity_in),
        .sel_velocity(sel_velocity), .res_12bit(res_12bit),
        .hold_n(hold_n), .loop_en(loop_en),
        .out_bus(out_bus), .out_clk(out_clk)
    );

    function automatic logic [12:0] expect_word(logic [11:0] a, logic [11:0] v,
                                                logic sel, logic res);
        int s;
        if (!sel) return res ? 13'(a) : 13'(a >> 2);
        s = v[11] ? int'(v) - 4096 : int'(v);
        if (!res) s = s >>> 2;
        return 13'(s);
    endfunction

    task automatic check(string req, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: called at a negedge; applies one strobe and queues the expectation
    task automatic put(logic [11:0] a, logic [11:0] v, logic sel, logic res);
        angle_in = a; velocity_in = v; sel_velocity = sel; res_12bit = res;
        smp_valid = 1'b1;
        if (hold_n && loop_en) expq.push_back(expect_word(a, v, sel, res));
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Monitor: pairs each rising data clock with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && out_clk && !prev_clk) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected pulse actual %h expected none", out_bus);
            end else begin
                check("R1 scoreboard", out_bus, expq.pop_front());
            end
        end
        prev_clk = out_clk;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R11 bus in reset", out_bus, 13'h0);
        check("R11 clk in reset", 13'(out_clk), 13'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R8: 12-bit angle and pulse shape
        put(12'hABC, 12'h000, 1'b0, 1'b1);
        check("R4 angle 12-bit", out_bus, 13'h0ABC);
        check("R8 clk low in settle cycle", 13'(out_clk), 13'h0);
        @(negedge clk);
        n = 0;
        while (out_clk && n < 20) begin n++; @(negedge clk); end
        check("R8 pulse width", 13'(n), 13'(PULSE));
        repeat (3) @(negedge clk);

        // R5: 10-bit angle
        put(12'hABC, 12'h000, 1'b0, 1'b0);
        check("R5 angle 10-bit", out_bus, 13'h02AF);
        repeat (6) @(negedge clk);

        // R6: velocity sign extension in both modes
        put(12'h000, 12'h800, 1'b1, 1'b1);
        check("R6 velocity 12-bit negative", out_bus, 13'h1800);
        repeat (6) @(negedge clk);
        put(12'h000, 12'hF00, 1'b1, 1'b0);
        check("R6 velocity 10-bit negative", out_bus, 13'h1FC0);
        repeat (6) @(negedge clk);
        put(12'h000, 12'h7FF, 1'b1, 1'b0);
        check("R6 velocity 10-bit positive", out_bus, 13'h01FF);
        repeat (6) @(negedge clk);

        // R7: select and resolution only matter at the strobe edge
        put(12'h123, 12'h456, 1'b1, 1'b1);
        sel_velocity = 1'b0; res_12bit = 1'b0;
        check("R7 select at strobe", out_bus, 13'h0456);
        @(negedge clk);
        check("R7 later select ignored", out_bus, 13'h0456);
        repeat (6) @(negedge clk);

        // R2: hold freezes the bus, stale sample not loaded on release
        hold_n = 1'b0;
        put(12'h111, 12'h000, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check("R2 bus held", out_bus, 13'h0456);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 no load after release", out_bus, 13'h0456);

        // R3: loop disabled freezes bus and clock
        loop_en = 1'b0;
        put(12'h222, 12'h000, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check("R3 bus frozen when loop off", out_bus, 13'h0456);
        loop_en = 1'b1;
        repeat (3) @(negedge clk);

        // R9: hold during the pulse drops the clock and it does not return
        put(12'h333, 12'h000, 1'b0, 1'b1);
        @(negedge clk);
        #1 hold_n = 1'b0;
        #1 check("R9 clk low same cycle", 13'(out_clk), 13'h0);
        @(negedge clk);
        #1 hold_n = 1'b1;
        @(negedge clk);
        #1 check("R9 pulse not resumed", 13'(out_clk), 13'h0);
        check("R9 bus kept", out_bus, 13'h0333);
        repeat (4) @(negedge clk);

        // R10: new sample during a pulse
        put(12'h444, 12'h000, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 clk high before restart", 13'(out_clk), 13'h1);
        put(12'h555, 12'h000, 1'b0, 1'b1);
        check("R10 new word loaded", out_bus, 13'h0555);
        check("R10 clk dropped", 13'(out_clk), 13'h0);
        @(negedge clk);
        check("R10 fresh pulse", 13'(out_clk), 13'h1);
        repeat (6) @(negedge clk);

        check("R1 all updates pulsed", 13'(expq.size()), 13'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule